// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block sits in front of a shared memory and keeps track of exclusive-access reservations for a fixed set of hardware contexts. When a context issues a load-linked, the monitor stores a reservation for the 64-byte granule that holds the address. When any write arrives, the monitor decides in the same cycle whether the write may go ahead, returns the store-conditional outcome, and drops the reservations that the write destroys.

Each context owns one table slot, which holds a valid bit and a granule tag. When a write is allowed, every reservation on the written granule is cleared, whichever context owns it. Each owner other than the writer that loses a reservation this way gets a one-cycle clear-exclusive pulse. A failed store-conditional changes nothing. The decision is combinational, and the table updates on the next rising clock edge.

Top module: `ll_sc_monitor`

## Requirements
- R1: After reset no reservation is held. A store-conditional then fails. With `req_valid_i` low, all outputs are 0.
- R2: A load-linked (`req_kind_i`=01) from a context that carries an ID reserves the granule `addr[31:6]` for that context. A later store-conditional from the same context to any address in that granule succeeds.
- R3: Each context holds at most one reservation. A new load-linked from that context replaces the granule it held before, so the old granule is no longer reserved.
- R4: A plain store (`req_kind_i`=10) always gives `allow_store_o`=1.
- R5: A store-conditional (`req_kind_i`=11) is allowed only when the issuing context holds a valid reservation whose granule matches the request. Otherwise `allow_store_o` and `sc_result_o` are both 0. A store-conditional with no context ID always fails.
- R6: A failed store-conditional leaves every reservation unchanged, including those of other contexts on the same granule.
- R7: An allowed write invalidates every reservation on its granule in all contexts, including the writer's own.
- R8: `clear_excl_o[i]` is high, in the cycle of the write, exactly for each context i other than the writer whose reservation the write invalidates. A write with no context ID counts as foreign to every owner.
- R9: `sc_result_o` is 1 for a successful store-conditional and 0 otherwise, including for every non-store-conditional request. All outputs are combinational in the request cycle.
- R10: A read (`req_kind_i`=00) has no effect. A load-linked without a context ID has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_kind_i | input | 2 | 00 read, 01 load-linked, 10 store, 11 store-conditional |
| req_ctx_valid_i | input | 1 | Request carries a context ID |
| req_ctx_i | input | 3 | Issuing context |
| req_addr_i | input | 32 | Byte address |
| allow_store_o | output | 1 | Write may proceed |
| sc_result_o | output | 1 | Store-conditional success |
| clear_excl_o | output | 8 | Per-context clear-exclusive pulse |

## Verification
The bench targets the following corner cases:
- **Addresses in the same granule but with different low bits.** A design that compared full addresses would fail these store-conditionals.
- **Several contexts reserving one granule, followed by a write from each context in turn.** A design that cleared only one matching slot would leave stale reservations. A design that notified the writer itself would pulse its own clear bit.
- **Failed store-conditionals aimed at a granule that other contexts have reserved.** A design that invalidated on failure would break those contexts' later store-conditionals.
- **Re-reservation, anonymous writes and anonymous load-linked requests.** A long pseudo-random run covers these and compares against a reference model.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [1:0] {
    KIND_READ  = 2'b00,
    KIND_LL    = 2'b01,
    KIND_STORE = 2'b10,
    KIND_SC    = 2'b11
  } req_kind_e;
endpackage

// File: rtl/llsc_slot.sv
module llsc_slot #(
  parameter int TAG_W = 26
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TAG_W-1:0] req_tag_i,
  input  logic             set_i,
  input  logic             kill_i,
  output logic             hit_o
);
  logic             vld_q;
  logic [TAG_W-1:0] tag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      tag_q <= '0;
    end else if (set_i) begin
      vld_q <= 1'b1;
      tag_q <= req_tag_i;
    end else if (kill_i) begin
      vld_q <= 1'b0;
    end
  end

  assign hit_o = vld_q && (tag_q == req_tag_i);
endmodule

// File: rtl/llsc_decide.sv
module llsc_decide
  import llsc_pkg::*;
#(
  parameter int NUM_CTX = 8,
  parameter int CTX_W   = 3
) (
  input  logic               req_valid_i,
  input  logic [1:0]         req_kind_i,
  input  logic               req_ctx_valid_i,
  input  logic [CTX_W-1:0]   req_ctx_i,
  input  logic [NUM_CTX-1:0] hit_i,
  output logic [NUM_CTX-1:0] set_o,
  output logic [NUM_CTX-1:0] kill_o,
  output logic               allow_o,
  output logic               sc_ok_o,
  output logic [NUM_CTX-1:0] clear_o
);
  logic [NUM_CTX-1:0] own_sel;
  logic               is_ll, is_st, is_sc;

  always_comb begin
    own_sel = '0;
    if (req_ctx_valid_i) own_sel[req_ctx_i] = 1'b1;
  end

  assign is_ll = req_valid_i && (req_kind_i == KIND_LL);
  assign is_st = req_valid_i && (req_kind_i == KIND_STORE);
  assign is_sc = req_valid_i && (req_kind_i == KIND_SC);

  // anonymous SC selects no slot and therefore fails
  assign sc_ok_o = is_sc && |(hit_i & own_sel);
  assign allow_o = is_st || sc_ok_o;
  assign kill_o  = allow_o ? hit_i : '0;
  assign clear_o = kill_o & ~own_sel;
  assign set_o   = is_ll ? own_sel : '0;
endmodule

// File: rtl/ll_sc_monitor.sv
module ll_sc_monitor #(
  parameter int NUM_CTX      = 8,
  parameter int ADDR_W       = 32,
  parameter int GRANULE_BITS = 6
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_valid_i,
  input  logic [1:0]                 req_kind_i,
  input  logic                       req_ctx_valid_i,
  input  logic [$clog2(NUM_CTX)-1:0] req_ctx_i,
  input  logic [ADDR_W-1:0]          req_addr_i,
  output logic                       allow_store_o,
  output logic                       sc_result_o,
  output logic [NUM_CTX-1:0]         clear_excl_o
);
  localparam int CTX_W = $clog2(NUM_CTX);
  localparam int TAG_W = ADDR_W - GRANULE_BITS;

  logic [TAG_W-1:0]   req_tag;
  logic [NUM_CTX-1:0] hit, set, kill;

  assign req_tag = req_addr_i[ADDR_W-1:GRANULE_BITS];

  for (genvar g = 0; g < NUM_CTX; g++) begin : g_slot
    llsc_slot #(.TAG_W(TAG_W)) u_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .req_tag_i (req_tag),
      .set_i     (set[g]),
      .kill_i    (kill[g]),
      .hit_o     (hit[g])
    );
  end

  llsc_decide #(.NUM_CTX(NUM_CTX), .CTX_W(CTX_W)) u_decide (
    .req_valid_i     (req_valid_i),
    .req_kind_i      (req_kind_i),
    .req_ctx_valid_i (req_ctx_valid_i),
    .req_ctx_i       (req_ctx_i),
    .hit_i           (hit),
    .set_o           (set),
    .kill_o          (kill),
    .allow_o         (allow_store_o),
    .sc_ok_o         (sc_result_o),
    .clear_o         (clear_excl_o)
  );
endmodule

// File: rtl/ll_sc_monitor_chk.sv
module ll_sc_monitor_chk #(
  parameter int NUM_CTX      = 8,
  parameter int ADDR_W       = 32,
  parameter int GRANULE_BITS = 6
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       req_valid_i,
  input logic [1:0]                 req_kind_i,
  input logic                       req_ctx_valid_i,
  input logic [$clog2(NUM_CTX)-1:0] req_ctx_i,
  input logic [ADDR_W-1:0]          req_addr_i,
  input logic                       allow_store_o,
  input logic                       sc_result_o,
  input logic [NUM_CTX-1:0]         clear_excl_o
);
  logic is_sc, is_ll;
  assign is_sc = req_valid_i && req_kind_i == 2'b11;
  assign is_ll = req_valid_i && req_kind_i == 2'b01;

  a_r4_store_allowed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_kind_i == 2'b10) |-> allow_store_o);

  a_r8_clear_needs_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|clear_excl_o) |-> allow_store_o);

  a_r8_no_self_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ctx_valid_i |-> !clear_excl_o[req_ctx_i]);

  a_r6_fail_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_sc && !sc_result_o) |-> (!allow_store_o && clear_excl_o == '0));

  a_r9_result_only_sc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sc_result_o |-> (is_sc && allow_store_o && req_ctx_valid_i));

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> (!allow_store_o && !sc_result_o && clear_excl_o == '0));

  a_r7_sc_consumes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_sc && sc_result_o) |=>
      !(is_sc && req_ctx_valid_i && req_ctx_i == $past(req_ctx_i) &&
        req_addr_i[ADDR_W-1:GRANULE_BITS] == $past(req_addr_i[ADDR_W-1:GRANULE_BITS]) &&
        sc_result_o));

  a_r2_ll_then_sc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_ll && req_ctx_valid_i) |=>
      (!(is_sc && req_ctx_valid_i && req_ctx_i == $past(req_ctx_i) &&
         req_addr_i[ADDR_W-1:GRANULE_BITS] == $past(req_addr_i[ADDR_W-1:GRANULE_BITS]))
       || sc_result_o));
endmodule

bind ll_sc_monitor ll_sc_monitor_chk #(
  .NUM_CTX(NUM_CTX), .ADDR_W(ADDR_W), .GRANULE_BITS(GRANULE_BITS)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
  .req_kind_i(req_kind_i), .req_ctx_valid_i(req_ctx_valid_i),
  .req_ctx_i(req_ctx_i), .req_addr_i(req_addr_i),
  .allow_store_o(allow_store_o), .sc_result_o(sc_result_o),
  .clear_excl_o(clear_excl_o)
);

// File: tb/ll_sc_monitor_bench.sv
module ll_sc_monitor_bench;
  localparam int N = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [1:0]  req_kind_i = 2'b00;
  logic        req_ctx_valid_i = 1'b0;
  logic [2:0]  req_ctx_i = '0;
  logic [31:0] req_addr_i = '0;
  logic        allow_store_o, sc_result_o;
  logic [N-1:0] clear_excl_o;

  int checks = 0;
  int fails  = 0;
  logic          mv[N];
  logic [25:0]   mt[N];

  always #2 clk_i = ~clk_i;

  ll_sc_monitor u_ll_sc_monitor (.*);

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  // drive at negedge, check just before posedge, model updates at posedge
  task automatic op(logic v, logic [1:0] k, logic cv, logic [2:0] c, logic [31:0] a,
                    string rq);
    logic [25:0]  tg;
    logic [N-1:0] h, own, kl;
    logic         ok, al;
    @(negedge clk_i);
    req_valid_i = v; req_kind_i = k; req_ctx_valid_i = cv; req_ctx_i = c; req_addr_i = a;
    tg = a[31:6];
    own = '0;
    if (cv) own[c] = 1'b1;
    for (int i = 0; i < N; i++) h[i] = mv[i] && mt[i] == tg;
    ok = v && k == 2'b11 && |(h & own);
    al = (v && k == 2'b10) || ok;
    kl = al ? h : '0;
    #1;
    chk({rq, " allow"}, 32'(allow_store_o), 32'(al));
    chk({rq, " sc"}, 32'(sc_result_o), 32'(ok));
    chk({rq, " clear"}, 32'(clear_excl_o), 32'(kl & ~own));
    @(posedge clk_i);
    for (int i = 0; i < N; i++) if (kl[i]) mv[i] = 1'b0;
    if (v && k == 2'b01 && cv) begin mv[c] = 1'b1; mt[c] = tg; end
    #0;
  endtask

  initial begin
    #(4 * 190000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    for (int i = 0; i < N; i++) begin mv[i] = 1'b0; mt[i] = '0; end
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    // R1: idle and SC after reset
    op(0, 2'b11, 1, 0, 32'h100, "R1");
    for (int c = 0; c < N; c++) op(1, 2'b11, 1, 3'(c), 32'h100, "R1");
    // R2: LL then SC on different offset in same granule
    for (int c = 0; c < N; c++) begin
      op(1, 2'b01, 1, 3'(c), 32'h1000 + 32'(c) * 64, "R2");
      op(1, 2'b11, 1, 3'(c), 32'h1000 + 32'(c) * 64 + 32'd63, "R2");
    end
    // R3: re-reservation drops the old granule
    op(1, 2'b01, 1, 3, 32'h2000, "R3");
    op(1, 2'b01, 1, 3, 32'h3000, "R3");
    op(1, 2'b11, 1, 3, 32'h2000, "R3");
    op(1, 2'b11, 1, 3, 32'h3004, "R3");
    // R7 / R8: all contexts share a granule, each writer in turn, store and SC
    for (int w = 0; w < N; w++) begin
      for (int c = 0; c < N; c++) op(1, 2'b01, 1, 3'(c), 32'h4000 + 32'(c), "R7");
      op(1, 2'b11, 1, 3'(w), 32'h4010, "R6");      // wrong? same granule -> success
      for (int c = 0; c < N; c++) op(1, 2'b11, 1, 3'(c), 32'h4020, "R7");
      for (int c = 0; c < N; c++) op(1, 2'b01, 1, 3'(c), 32'h4000, "R8");
      op(1, 2'b10, 1, 3'(w), 32'h4030, "R4");
      op(1, 2'b11, 1, 3'(w), 32'h4000, "R7");
    end
    // R6: failed SC leaves others intact
    for (int c = 0; c < N; c++) op(1, 2'b01, 1, 3'(c), 32'h5000, "R6");
    op(1, 2'b11, 1, 0, 32'h6000, "R6");
    op(1, 2'b11, 0, 1, 32'h5000, "R5");
    for (int c = 0; c < N; c++) op(1, 2'b11, 1, 3'(c), 32'h5000, "R6");
    // R8: anonymous store notifies every owner
    for (int c = 0; c < N; c++) op(1, 2'b01, 1, 3'(c), 32'h7000, "R8");
    op(1, 2'b10, 0, 0, 32'h7008, "R8");
    // R10: read and anonymous LL have no effect
    op(1, 2'b00, 1, 2, 32'h8000, "R10");
    op(1, 2'b01, 0, 2, 32'h8000, "R10");
    op(1, 2'b11, 1, 2, 32'h8000, "R10");
    // R9 / R5: pseudo-random mix across four granules
    lf = 16'hACE1;
    for (int n = 0; n < 4000; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      op(lf[0] | lf[1], lf[3:2], lf[4] | lf[5], lf[8:6],
         32'h9000 + 32'(lf[10:9]) * 64 + 32'(lf[15:11]), "R9");
    end
    // R1: reset clears everything
    op(1, 2'b01, 1, 5, 32'hA000, "R1");
    @(negedge clk_i);
    req_valid_i = 0;
    rst_ni = 0;
    for (int i = 0; i < N; i++) mv[i] = 1'b0;
    @(negedge clk_i);
    rst_ni = 1;
    op(1, 2'b11, 1, 5, 32'hA000, "R1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule